// File: doc/BRIEF.md
# Track Cache Write-Policy Controller

This block is the control logic of a small, fully associative, track-granular cache directory that sits in front of a disk backend. A requester presents one request at a time: a read, a write-through write or a fast write, each with a track number. The controller looks the track up in its tag store. On a miss it picks a victim entry, writes that entry back to disk first if it holds modified data, fetches the whole requested track, and installs it. It then completes the request according to its type. The data arrays, the disk and the nonvolatile mirror are outside the block. The controller reaches them through plain valid/ready command channels that carry only a track number.

The two write policies differ in when completion is reported. A write-through write marks the track modified and sends it to disk. The requester sees completion only after the disk accepts the write, and the track is then clean. A fast write marks the track modified and reports completion at once. After that it mirrors the track to the nonvolatile copy, and the track stays modified. Modified tracks are written back in the background in two cases: when a free-running period timer expires, which drains all of them, or when the modified-track count rises above a threshold input, which drains them until the count is back at or below the threshold.

Top module: `trackCacheCtl`

## Requirements
- R1: After reset, `reqReady` is 1, `rspValid`, `stageValid`, `diskWrValid` and `nvValid` are 0, and the directory is empty, so the first access to any track misses.
- R2: On a miss of any request type (`reqOp` 0 = read, 1 = write-through, 2 = fast write; 3 acts as a read), exactly one stage command carrying the requested track completes before the response. The response has `rspHit` = 0.
- R3: On a hit, no stage command is issued and the response has `rspHit` = 1.
- R4: A write-through issues one disk write with `diskWrDestage` = 0 for its track. `rspValid` rises only in a cycle after that handshake completes. Afterwards the track is clean, so it never causes a background destage.
- R5: A fast write raises `rspValid` without waiting for any disk or nonvolatile handshake. After the response it issues one nonvolatile command for its track, and it issues no disk write.
- R6: The victim on a miss is the lowest-numbered empty entry if one exists. Otherwise it is the least recently used entry, where both a hit and a fill count as a use.
- R7: If the victim holds a modified track, a disk write with `diskWrDestage` = 1 for the victim's track completes before the stage command for the new track.
- R8: When idle and the number of modified tracks exceeds `cfgThresh`, the block destages modified entries (lowest entry index first, `diskWrDestage` = 1), one at a time, until the count is no greater than `cfgThresh`. A destaged track stays valid and still hits.
- R9: Every `PERIOD` cycles a drain is triggered, and all modified tracks are destaged. Before the first expiry, no modified track is destaged unless the threshold is exceeded.
- R10: From acceptance until the response, `reqReady` stays 0. `rspValid` is a single-cycle pulse.
- R11: While any command valid is high and its ready is low, the valid stays high and its track stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgThresh | input | CNT_W | Modified-track count above which destaging starts |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted this cycle when high with reqValid |
| reqOp | input | 2 | 0 read, 1 write-through, 2 fast write, 3 read |
| reqTrack | input | TRACK_W | Requested track number |
| rspValid | output | 1 | Completion pulse |
| rspHit | output | 1 | Request hit in the directory (valid with rspValid) |
| stageValid | output | 1 | Fetch-from-disk command |
| stageReady | input | 1 | Fetch accepted and finished |
| stageTrack | output | TRACK_W | Track to fetch |
| diskWrValid | output | 1 | Disk write command |
| diskWrReady | input | 1 | Disk write finished |
| diskWrTrack | output | TRACK_W | Track to write |
| diskWrDestage | output | 1 | 1 for write-back of a modified track, 0 for write-through |
| nvValid | output | 1 | Nonvolatile mirror command |
| nvReady | input | 1 | Mirror finished |
| nvTrack | output | TRACK_W | Track to mirror |

## Verification
The hardest situation to reach is an eviction of a modified victim. The track must have been fast-written, then aged to least recently used by later fills, while staying below the destage threshold and finishing before the period timer expires. The stimulus resets, keeps the threshold at its maximum, fast-writes one track, fills the remaining entries with reads, and then misses once more. It checks that the write-back event carries an earlier timestamp than the fetch. Threshold and period drains are exercised separately, with the threshold forced to 0 or 1 and the period shortened. A long arithmetic read sweep is compared against a least-recently-used list kept in the bench.

// File: rtl/tccPkg.sv
package tccPkg;

  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_WT   = 2'd1,
    OP_FW   = 2'd2
  } opE;

  typedef enum logic [3:0] {
    S_IDLE, S_LOOK, S_EVICT, S_STAGE, S_UPD, S_DWR, S_RSP, S_NVM, S_BGD
  } stE;

  // strobes from control to the directory datapath
  typedef struct packed {
    logic touch;
    logic install;
    logic setDirty;
    logic clrDirty;
  } dirCmdS;

endpackage

// File: rtl/tccDirectory.sv
module tccDirectory
  import tccPkg::*;
#(
  parameter int WAYS    = 4,
  parameter int TRACK_W = 12,
  parameter int PERIOD  = 4096,
  localparam int IW  = $clog2(WAYS),
  localparam int CW  = $clog2(WAYS + 1),
  localparam int TMW = $clog2(PERIOD)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TRACK_W-1:0] trackIn,
  input  dirCmdS             cmd,
  input  logic [IW-1:0]      cmdIdx,
  output logic               hit,
  output logic [IW-1:0]      hitIdx,
  output logic [IW-1:0]      vicIdx,
  output logic               vicValid,
  output logic               vicDirty,
  output logic [TRACK_W-1:0] vicTrack,
  output logic               anyDirty,
  output logic [IW-1:0]      dirtyIdx,
  output logic [TRACK_W-1:0] dirtyTrack,
  output logic [CW-1:0]      dirtyCount,
  output logic               periodPend
);

  logic [TRACK_W-1:0] tagQ [WAYS];
  logic [IW-1:0]      ageQ [WAYS];
  logic [WAYS-1:0]    validQ, dirtyQ, matchV;
  logic [CW-1:0]      dCntQ;
  logic [TMW-1:0]     tmrQ;
  logic               fire;

  for (genvar g = 0; g < WAYS; g++) begin : gMatch
    assign matchV[g] = validQ[g] && (tagQ[g] == trackIn);
  end

  // priority encoders: lowest index wins
  always_comb begin
    hitIdx   = '0;
    dirtyIdx = '0;
    vicIdx   = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (ageQ[i] == IW'(WAYS - 1)) vicIdx = IW'(i);
    end
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (matchV[i]) hitIdx = IW'(i);
      if (dirtyQ[i]) dirtyIdx = IW'(i);
      if (!validQ[i]) vicIdx = IW'(i);
    end
  end

  assign hit        = |matchV;
  assign vicValid   = validQ[vicIdx];
  assign vicDirty   = dirtyQ[vicIdx];
  assign vicTrack   = tagQ[vicIdx];
  assign anyDirty   = |dirtyQ;
  assign dirtyTrack = tagQ[dirtyIdx];
  assign dirtyCount = dCntQ;
  assign fire       = (tmrQ == TMW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < WAYS; j++) begin
        tagQ[j] <= '0;
        ageQ[j] <= IW'(j);
      end
      validQ     <= '0;
      dirtyQ     <= '0;
      dCntQ      <= '0;
      tmrQ       <= '0;
      periodPend <= 1'b0;
    end else begin
      if (cmd.touch) begin
        for (int j = 0; j < WAYS; j++) begin
          if (IW'(j) == cmdIdx) ageQ[j] <= '0;
          else if (ageQ[j] < ageQ[cmdIdx]) ageQ[j] <= ageQ[j] + IW'(1);
        end
      end
      if (cmd.install) begin
        tagQ[cmdIdx]   <= trackIn;
        validQ[cmdIdx] <= 1'b1;
      end
      if (cmd.setDirty) dirtyQ[cmdIdx] <= 1'b1;
      else if (cmd.clrDirty || cmd.install) dirtyQ[cmdIdx] <= 1'b0;
      if (cmd.setDirty && !dirtyQ[cmdIdx]) dCntQ <= dCntQ + CW'(1);
      else if (cmd.clrDirty && dirtyQ[cmdIdx]) dCntQ <= dCntQ - CW'(1);
      tmrQ <= fire ? '0 : tmrQ + TMW'(1);
      if (fire) periodPend <= 1'b1;
      else if (!anyDirty) periodPend <= 1'b0;
    end
  end

  AST_DIRTY_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    32'(dCntQ) == $countones(dirtyQ)); // R8
  AST_INSTALL_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    cmd.install |-> !dirtyQ[cmdIdx]); // R7
  AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchV)); // R3
  AST_TOUCH_MRU: assert property (@(posedge clk) disable iff (!rstN)
    cmd.touch |=> ageQ[$past(cmdIdx)] == '0); // R6

endmodule

// File: rtl/tccControl.sv
module tccControl
  import tccPkg::*;
#(
  parameter int WAYS    = 4,
  parameter int TRACK_W = 12,
  localparam int IW = $clog2(WAYS),
  localparam int CW = $clog2(WAYS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CW-1:0]      cfgThresh,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [1:0]         reqOp,
  input  logic [TRACK_W-1:0] reqTrack,
  output logic               rspValid,
  output logic               rspHit,
  output logic               stageValid,
  input  logic               stageReady,
  output logic               diskWrValid,
  input  logic               diskWrReady,
  output logic [TRACK_W-1:0] diskWrTrack,
  output logic               diskWrDestage,
  output logic               nvValid,
  input  logic               nvReady,
  output logic [TRACK_W-1:0] curTrack,
  output dirCmdS             cmd,
  output logic [IW-1:0]      cmdIdx,
  input  logic               hit,
  input  logic [IW-1:0]      hitIdx,
  input  logic [IW-1:0]      vicIdx,
  input  logic               vicValid,
  input  logic               vicDirty,
  input  logic [TRACK_W-1:0] vicTrack,
  input  logic               anyDirty,
  input  logic [IW-1:0]      dirtyIdx,
  input  logic [TRACK_W-1:0] dirtyTrack,
  input  logic [CW-1:0]      dirtyCount,
  input  logic               periodPend
);

  stE                 stQ, stNxt;
  opE                 opQ;
  logic [TRACK_W-1:0] trackQ, evTrackQ;
  logic [IW-1:0]      idxQ;
  logic               hitQ, bgNeed;

  assign bgNeed   = anyDirty && (periodPend || (dirtyCount > cfgThresh));
  assign curTrack = trackQ;
  assign rspHit   = hitQ;

  always_comb begin
    stNxt         = stQ;
    cmd           = '0;
    cmdIdx        = idxQ;
    reqReady      = 1'b0;
    stageValid    = 1'b0;
    diskWrValid   = 1'b0;
    diskWrDestage = 1'b0;
    diskWrTrack   = trackQ;
    nvValid       = 1'b0;
    rspValid      = 1'b0;
    case (stQ)
      S_IDLE: begin
        if (bgNeed) stNxt = S_BGD;
        else begin
          reqReady = 1'b1;
          if (reqValid) stNxt = S_LOOK;
        end
      end
      S_LOOK: stNxt = hit ? S_UPD : ((vicValid && vicDirty) ? S_EVICT : S_STAGE);
      S_EVICT: begin
        diskWrValid   = 1'b1;
        diskWrDestage = 1'b1;
        diskWrTrack   = evTrackQ;
        if (diskWrReady) begin
          cmd.clrDirty = 1'b1;
          stNxt        = S_STAGE;
        end
      end
      S_STAGE: begin
        stageValid = 1'b1;
        if (stageReady) begin
          cmd.install = 1'b1;
          cmd.touch   = 1'b1;
          stNxt       = S_UPD;
        end
      end
      S_UPD: begin
        cmd.touch    = 1'b1;
        cmd.setDirty = (opQ != OP_READ);
        stNxt        = (opQ == OP_WT) ? S_DWR : S_RSP;
      end
      S_DWR: begin
        diskWrValid = 1'b1;
        if (diskWrReady) begin
          cmd.clrDirty = 1'b1;
          stNxt        = S_RSP;
        end
      end
      S_RSP: begin
        rspValid = 1'b1;
        stNxt    = (opQ == OP_FW) ? S_NVM : S_IDLE;
      end
      S_NVM: begin
        nvValid = 1'b1;
        if (nvReady) stNxt = S_IDLE;
      end
      S_BGD: begin
        diskWrValid   = 1'b1;
        diskWrDestage = 1'b1;
        diskWrTrack   = dirtyTrack;
        cmdIdx        = dirtyIdx;
        if (diskWrReady) begin
          cmd.clrDirty = 1'b1;
          stNxt        = S_IDLE;
        end
      end
      default: stNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ      <= S_IDLE;
      opQ      <= OP_READ;
      trackQ   <= '0;
      evTrackQ <= '0;
      idxQ     <= '0;
      hitQ     <= 1'b0;
    end else begin
      stQ <= stNxt;
      if (reqReady && reqValid) begin
        opQ    <= (reqOp == 2'd3) ? OP_READ : opE'(reqOp);
        trackQ <= reqTrack;
      end
      if (stQ == S_LOOK) begin
        idxQ     <= hit ? hitIdx : vicIdx;
        hitQ     <= hit;
        evTrackQ <= vicTrack;
      end
    end
  end

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R10
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R10
  AST_WT_DISK_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && opQ == OP_WT) |-> $past(diskWrValid && diskWrReady && !diskWrDestage)); // R4
  AST_FW_NO_DISK: assert property (@(posedge clk) disable iff (!rstN)
    (opQ == OP_FW && stQ != S_IDLE) |-> !(diskWrValid && !diskWrDestage)); // R5
  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stageValid && !stageReady) |=> (stageValid && $stable(trackQ))); // R11
  AST_DW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (diskWrValid && !diskWrReady) |=> (diskWrValid && $stable(diskWrTrack))); // R11

endmodule

// File: rtl/trackCacheCtl.sv
module trackCacheCtl
  import tccPkg::*;
#(
  parameter int WAYS    = 4,
  parameter int TRACK_W = 12,
  parameter int PERIOD  = 4096,
  localparam int IW    = $clog2(WAYS),
  localparam int CNT_W = $clog2(WAYS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CNT_W-1:0]   cfgThresh,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [1:0]         reqOp,
  input  logic [TRACK_W-1:0] reqTrack,
  output logic               rspValid,
  output logic               rspHit,
  output logic               stageValid,
  input  logic               stageReady,
  output logic [TRACK_W-1:0] stageTrack,
  output logic               diskWrValid,
  input  logic               diskWrReady,
  output logic [TRACK_W-1:0] diskWrTrack,
  output logic               diskWrDestage,
  output logic               nvValid,
  input  logic               nvReady,
  output logic [TRACK_W-1:0] nvTrack
);

  dirCmdS             cmd;
  logic [IW-1:0]      cmdIdx, hitIdx, vicIdx, dirtyIdx;
  logic [TRACK_W-1:0] curTrack, vicTrack, dirtyTrack;
  logic [CNT_W-1:0]   dirtyCount;
  logic               hit, vicValid, vicDirty, anyDirty, periodPend;

  assign stageTrack = curTrack;
  assign nvTrack    = curTrack;

  tccControl #(.WAYS(WAYS), .TRACK_W(TRACK_W)) uCtl (
    .clk(clk), .rstN(rstN), .cfgThresh(cfgThresh),
    .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp), .reqTrack(reqTrack),
    .rspValid(rspValid), .rspHit(rspHit),
    .stageValid(stageValid), .stageReady(stageReady),
    .diskWrValid(diskWrValid), .diskWrReady(diskWrReady),
    .diskWrTrack(diskWrTrack), .diskWrDestage(diskWrDestage),
    .nvValid(nvValid), .nvReady(nvReady),
    .curTrack(curTrack), .cmd(cmd), .cmdIdx(cmdIdx),
    .hit(hit), .hitIdx(hitIdx), .vicIdx(vicIdx), .vicValid(vicValid),
    .vicDirty(vicDirty), .vicTrack(vicTrack), .anyDirty(anyDirty),
    .dirtyIdx(dirtyIdx), .dirtyTrack(dirtyTrack), .dirtyCount(dirtyCount),
    .periodPend(periodPend)
  );

  tccDirectory #(.WAYS(WAYS), .TRACK_W(TRACK_W), .PERIOD(PERIOD)) uDir (
    .clk(clk), .rstN(rstN), .trackIn(curTrack), .cmd(cmd), .cmdIdx(cmdIdx),
    .hit(hit), .hitIdx(hitIdx), .vicIdx(vicIdx), .vicValid(vicValid),
    .vicDirty(vicDirty), .vicTrack(vicTrack), .anyDirty(anyDirty),
    .dirtyIdx(dirtyIdx), .dirtyTrack(dirtyTrack), .dirtyCount(dirtyCount),
    .periodPend(periodPend)
  );

endmodule

// File: tb/trackCacheCtl_test.sv
module trackCacheCtl_test;

  localparam int WAYS = 4;
  localparam int TW   = 8;
  localparam int PER  = 500;
  localparam int CW   = $clog2(WAYS + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CW-1:0] cfgThresh = CW'(7);
  logic reqValid = 1'b0;
  logic [1:0] reqOp = 2'd0;
  logic [TW-1:0] reqTrack = '0;
  logic reqReady, rspValid, rspHit;
  logic stageValid, stageReady, diskWrValid, diskWrReady, diskWrDestage, nvValid, nvReady;
  logic [TW-1:0] stageTrack, diskWrTrack, nvTrack;

  always #2 clk = ~clk;

  int stLat = 2, dwLat = 0, nvLat = 0;
  int stCnt = 0, dwCntR = 0, nvCntR = 0;
  assign stageReady  = stageValid && (stCnt >= stLat);
  assign diskWrReady = diskWrValid && (dwCntR >= dwLat);
  assign nvReady     = nvValid && (nvCntR >= nvLat);
  always @(posedge clk) begin
    stCnt  <= (stageValid && !stageReady) ? stCnt + 1 : 0;
    dwCntR <= (diskWrValid && !diskWrReady) ? dwCntR + 1 : 0;
    nvCntR <= (nvValid && !nvReady) ? nvCntR + 1 : 0;
  end

  trackCacheCtl #(.WAYS(WAYS), .TRACK_W(TW), .PERIOD(PER)) uut (
    .clk(clk), .rstN(rstN), .cfgThresh(cfgThresh),
    .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp), .reqTrack(reqTrack),
    .rspValid(rspValid), .rspHit(rspHit),
    .stageValid(stageValid), .stageReady(stageReady), .stageTrack(stageTrack),
    .diskWrValid(diskWrValid), .diskWrReady(diskWrReady), .diskWrTrack(diskWrTrack),
    .diskWrDestage(diskWrDestage),
    .nvValid(nvValid), .nvReady(nvReady), .nvTrack(nvTrack)
  );

  int total = 0, bad = 0;
  int evt = 0;
  int stageN = 0, wtN = 0, destN = 0, nvN = 0;
  int lastStage = -1, lastWt = -1, lastDest = -1, lastNv = -1;
  int stageStamp = 0, destStamp = 0;
  int holdErr = 0, busyErr = 0, pulseErr = 0;
  int rspNv = 0, rspWt = 0, rspDest = 0;
  logic prevStStall = 1'b0, prevDwStall = 1'b0;
  logic [TW-1:0] prevStTrk = '0, prevDwTrk = '0;

  always @(negedge clk) begin
    if (prevStStall && !(stageValid && stageTrack == prevStTrk)) holdErr++;
    if (prevDwStall && !(diskWrValid && diskWrTrack == prevDwTrk)) holdErr++;
    prevStStall = rstN && stageValid && !stageReady;
    prevDwStall = rstN && diskWrValid && !diskWrReady;
    prevStTrk = stageTrack;
    prevDwTrk = diskWrTrack;
    if (rstN && stageValid && stageReady) begin
      stageN++; lastStage = int'(stageTrack); evt++; stageStamp = evt;
    end
    if (rstN && diskWrValid && diskWrReady) begin
      evt++;
      if (diskWrDestage) begin destN++; lastDest = int'(diskWrTrack); destStamp = evt; end
      else begin wtN++; lastWt = int'(diskWrTrack); end
    end
    if (rstN && nvValid && nvReady) begin nvN++; lastNv = int'(nvTrack); end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    reqValid = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic doReq(input int op, input int trk, output bit hitOut);
    @(negedge clk);
    reqValid = 1'b1;
    reqOp = 2'(op);
    reqTrack = TW'(trk);
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    while (!rspValid) begin
      if (reqReady) busyErr++;
      @(negedge clk);
    end
    hitOut = rspHit;
    rspNv = nvN; rspWt = wtN; rspDest = destN;
    @(negedge clk);
    if (rspValid) pulseErr++;
  endtask

  int lru[WAYS];
  int lruN;

  initial begin : main
    bit h;
    int s0, d0, n0, w0;
    doReset();
    // R1 reset state
    chk(reqReady == 1'b1, "R1 reqReady", int'(reqReady), 1);
    chk(!rspValid && !stageValid && !diskWrValid && !nvValid, "R1 valids idle",
        int'(rspValid | stageValid | diskWrValid | nvValid), 0);

    // R2 / R3 read miss then hit
    s0 = stageN;
    doReq(0, 10, h);
    chk(h == 1'b0, "R1 R2 first read misses", int'(h), 0);
    chk(stageN == s0 + 1 && lastStage == 10, "R2 stage of track", lastStage, 10);
    doReq(0, 10, h);
    chk(h == 1'b1, "R3 hit flag", int'(h), 1);
    chk(stageN == s0 + 1, "R3 no stage on hit", stageN, s0 + 1);

    // R4 write-through miss with slow disk
    dwLat = 6;
    s0 = stageN; w0 = wtN;
    doReq(1, 20, h);
    chk(h == 1'b0 && stageN == s0 + 1, "R2 write-through miss staged", stageN, s0 + 1);
    chk(rspWt == w0 + 1 && lastWt == 20, "R4 disk write before response", rspWt, w0 + 1);
    dwLat = 0;

    // R5 fast write hit with slow mirror
    nvLat = 10;
    n0 = nvN; w0 = wtN; d0 = destN;
    doReq(2, 10, h);
    chk(rspNv == n0, "R5 response before mirror", rspNv, n0);
    repeat (20) @(negedge clk);
    chk(nvN == n0 + 1 && lastNv == 10, "R5 mirror of track", lastNv, 10);
    chk(wtN == w0 && destN == d0, "R5 no disk write", wtN + destN, w0 + d0);
    nvLat = 0;

    // R4 write-through leaves the track clean
    doReq(1, 10, h);
    chk(h == 1'b1 && lastWt == 10, "R4 write-through hit to disk", lastWt, 10);
    d0 = destN;
    cfgThresh = CW'(0);
    repeat (20) @(negedge clk);
    chk(destN == d0, "R4 track clean after write-through", destN, d0);
    // R8 threshold zero drains a fresh fast write
    doReq(2, 30, h);
    repeat (20) @(negedge clk);
    chk(destN == d0 + 1 && lastDest == 30, "R8 destage at threshold 0", lastDest, 30);
    cfgThresh = CW'(7);

    // R6 least recently used victim
    doReset();
    doReq(0, 1, h); doReq(0, 2, h); doReq(0, 3, h); doReq(0, 4, h);
    doReq(0, 1, h);
    chk(h == 1'b1, "R6 touch hit", int'(h), 1);
    doReq(0, 5, h);
    doReq(0, 3, h);
    chk(h == 1'b1, "R6 recent track kept", int'(h), 1);
    doReq(0, 2, h);
    chk(h == 1'b0, "R6 oldest track evicted", int'(h), 0);

    // R7 dirty victim written back before fetch
    doReset();
    doReq(2, 1, h);
    doReq(0, 2, h); doReq(0, 3, h); doReq(0, 4, h);
    d0 = destN;
    doReq(0, 5, h);
    chk(destN == d0 + 1 && lastDest == 1, "R7 victim destaged", lastDest, 1);
    chk(destStamp < stageStamp && lastStage == 5, "R7 destage precedes stage", destStamp, stageStamp - 1);

    // R8 threshold one
    doReset();
    cfgThresh = CW'(1);
    d0 = destN;
    doReq(2, 1, h);
    doReq(2, 2, h);
    repeat (20) @(negedge clk);
    chk(destN == d0 + 1 && lastDest == 1, "R8 lowest entry destaged", lastDest, 1);
    doReq(0, 1, h);
    chk(h == 1'b1, "R8 destaged track still hits", int'(h), 1);
    repeat (20) @(negedge clk);
    chk(destN == d0 + 1, "R8 stops at threshold", destN, d0 + 1);
    cfgThresh = CW'(7);

    // R9 periodic drain
    doReset();
    d0 = destN;
    doReq(2, 9, h);
    repeat (240) @(negedge clk);
    chk(destN == d0, "R9 no destage before period", destN, d0);
    repeat (320) @(negedge clk);
    chk(destN == d0 + 1 && lastDest == 9, "R9 destage after period", lastDest, 9);

    // R6 R2 R3 sweep against an LRU list
    doReset();
    lruN = 0;
    for (int i = 0; i < 48; i++) begin
      int t, pos;
      t = (i * 5 + i / 4) % 7;
      pos = -1;
      for (int k = 0; k < lruN; k++) if (lru[k] == t) pos = k;
      s0 = stageN;
      doReq((i % 4 == 3) ? 3 : 0, t, h);
      chk(h == (pos >= 0), "R6 sweep hit", int'(h), int'(pos >= 0));
      chk(stageN == s0 + ((pos >= 0) ? 0 : 1), "R2 sweep stage count", stageN - s0, (pos >= 0) ? 0 : 1);
      if (pos < 0) begin
        if (lruN < WAYS) lruN++;
        pos = lruN - 1;
      end
      for (int k = pos; k > 0; k--) lru[k] = lru[k - 1];
      lru[0] = t;
    end

    chk(busyErr == 0, "R10 reqReady low while busy", busyErr, 0);
    chk(pulseErr == 0, "R10 single-cycle response", pulseErr, 0);
    chk(holdErr == 0, "R11 command held while stalled", holdErr, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule